// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block counts coins toward a fixed sale price of 15 units and signals when the sale may be released. Two coin types are accepted: a small coin worth 5 units and a large coin worth 10 units. Each has its own sense line, and each line is asynchronous to the block clock. Each line is brought into the clock domain and reduced to a single-cycle event per coin. The running credit is held in a five-state Moore machine.

When a payment reaches exactly 15, the release output is raised for one clock and the credit returns to zero. When a payment reaches 20, the release output is raised for one clock and the 5-unit surplus is kept as opening credit for the next sale. The asynchronous active-low reset clears all state. Its release is synchronised inside the block, so internal state leaves reset two clock edges after `rst_n` rises.

Top module: `vend_credit_ctrl`

## Requirements
- R1: While reset is applied, `sale_release_o` is 0. After reset the credit is zero, so two small coins alone do not raise `sale_release_o` and a third one does.
- R2: A coin is recognised on a 0-to-1 transition of its sense line after two synchroniser flops. A line held high for many cycles counts as exactly one coin.
- R3: A sense line first seen high at clock edge k changes the credit at edge k+1. A release caused by that coin is visible on `sale_release_o` after edge k+1.
- R4: In the credit states 0, 5 and 10, a cycle with no coin event leaves the credit unchanged, however many such cycles pass.
- R5: Credit advances as follows: 0 goes to 5 on a small coin and to 10 on a large coin. 5 goes to 10 on a small coin and to paid-15 on a large coin. 10 goes to paid-15 on a small coin and to paid-20 on a large coin.
- R6: `sale_release_o` is 1 exactly in the paid-15 and paid-20 states. It never stays high for two consecutive cycles, and paid-15 returns to credit 0 on the next clock.
- R7: Paid-20 returns to credit 5 on the next clock, so a following large coin completes another sale.
- R8: If both coin events occur in the same cycle, the large coin is counted and the small coin is discarded.
- R9: A coin event arriving while the machine is in paid-15 or paid-20 is discarded and does not change the credit that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nickel_sense_i | input | 1 | Asynchronous sense line for the 5-unit coin |
| dime_sense_i | input | 1 | Asynchronous sense line for the 10-unit coin |
| sale_release_o | output | 1 | High for one clock when a sale is paid |

## Verification
The hardest case to reach from the ports is a coin event that lands in the single cycle the machine spends in a paid state. The event must be raised by the other coin line one cycle after the paying coin's line, so that the two synchroniser pipelines deliver their events on consecutive edges. The stimulus builds that offset for both paid states and then spends more coins. This shows that the discarded coin left the carried credit at 0 or 5. A cycle-accurate scoreboard predicts `sale_release_o` on every clock, so any shift in synchroniser latency also shows up.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Credit held by the controller; paid states drive the release output.
  typedef enum logic [2:0] {
    CR0    = 3'd0,
    CR5    = 3'd1,
    CR10   = 3'd2,
    PAID15 = 3'd3,
    PAID20 = 3'd4
  } credit_e;

  localparam int COIN_LINES = 2;
  localparam int LINE_SMALL = 0;
  localparam int LINE_LARGE = 1;

endpackage

// File: rtl/vend_rst_sync.sv
module vend_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] rel_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rel_q <= '0;
    else         rel_q <= {rel_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = rel_q[STAGES-1];

endmodule

// File: rtl/vend_coin_sync.sv
module vend_coin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_raw,
  output logic coin_evt
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], sense_raw};
  end

  // rising edge seen between the last two stages
  assign coin_evt = chain_q[LAST-1] & ~chain_q[LAST];

  // R2: one coin never yields back-to-back events
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    coin_evt |=> !coin_evt);

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic small_evt,
  input  logic large_evt,
  output logic paid
);

  credit_e cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    case (cur_q)
      CR0: begin
        if (large_evt)      nxt = CR10;
        else if (small_evt) nxt = CR5;
      end
      CR5: begin
        if (large_evt)      nxt = PAID15;
        else if (small_evt) nxt = CR10;
      end
      CR10: begin
        if (large_evt)      nxt = PAID20;
        else if (small_evt) nxt = PAID15;
      end
      PAID15:  nxt = CR0;
      PAID20:  nxt = CR5;
      default: nxt = CR0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= CR0;
    else        cur_q <= nxt;
  end

  assign paid = (cur_q == PAID15) || (cur_q == PAID20);

  // R4: idle cycles keep the credit
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_q inside {CR0, CR5, CR10}) && !small_evt && !large_evt) |=> $stable(cur_q));

  // R8: large coin wins a collision from zero credit
  a_r8_large_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == CR0 && large_evt) |=> (cur_q == CR10));

  // R6: paid-15 always clears the credit
  a_r6_paid15_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == PAID15) |=> (cur_q == CR0));

  // R7: paid-20 keeps the surplus
  a_r7_paid20_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == PAID20) |=> (cur_q == CR5));

  // R5: a large coin at credit 10 reaches paid-20
  a_r5_ten_plus_large: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == CR10 && large_evt) |=> (cur_q == PAID20));

endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
  import vend_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nickel_sense_i,
  input  logic dime_sense_i,
  output logic sale_release_o
);

  logic                  int_rst_n;
  logic [COIN_LINES-1:0] sense_v;
  logic [COIN_LINES-1:0] evt_v;

  assign sense_v[LINE_SMALL] = nickel_sense_i;
  assign sense_v[LINE_LARGE] = dime_sense_i;

  vend_rst_sync #(.STAGES(RESET_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (int_rst_n)
  );

  for (genvar g = 0; g < COIN_LINES; g++) begin : g_line
    vend_coin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (int_rst_n),
      .sense_raw (sense_v[g]),
      .coin_evt  (evt_v[g])
    );
  end

  vend_credit_fsm u_fsm (
    .clk       (clk),
    .rst_n     (int_rst_n),
    .small_evt (evt_v[LINE_SMALL]),
    .large_evt (evt_v[LINE_LARGE]),
    .paid      (sale_release_o)
  );

  // R6: release is a one-clock strobe
  a_r6_release_strobe: assert property (@(posedge clk) disable iff (!int_rst_n)
    sale_release_o |=> !sale_release_o);

  // R1: nothing is released while the block is held in reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!sale_release_o || int_rst_n);
  end

endmodule

// File: tb/vend_credit_ctrl_tb_top.sv
module vend_credit_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic rel;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state (0:cr0 1:cr5 2:cr10 3:paid15 4:paid20)
  int  m_st = 0;
  bit  m_n0 = 0, m_n1 = 0, m_d0 = 0, m_d1 = 0;

  always #4 clk = ~clk;

  vend_credit_ctrl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .nickel_sense_i (nickel),
    .dime_sense_i   (dime),
    .sale_release_o (rel)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sale_release_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: sets the sense lines for one cycle and predicts the release after the next edge
  task automatic drive(input bit n, input bit d, input string tag);
    bit pn, pd;
    @(negedge clk);
    nickel = n;
    dime   = d;
    pn = m_n0 & ~m_n1;
    pd = m_d0 & ~m_d1;
    case (m_st)
      0: m_st = pd ? 2 : (pn ? 1 : 0);
      1: m_st = pd ? 3 : (pn ? 2 : 1);
      2: m_st = pd ? 4 : (pn ? 3 : 2);
      3: m_st = 0;
      default: m_st = 1;
    endcase
    m_n1 = m_n0; m_n0 = n;
    m_d1 = m_d0; m_d0 = d;
    exp_q.push_back('{exp: (m_st >= 3), tag: tag});
  endtask

  task automatic coin(input bit n, input bit d, input string tag);
    drive(n, d, tag);
    drive(1'b0, 1'b0, tag);
    drive(1'b0, 1'b0, tag);
  endtask

  // monitor: compares one prediction per clock
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(rel, e.exp, e.tag);
    end
  end

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check(rel, 1'b0, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check(rel, 1'b0, "R1 after reset");

    // R1 R4: two small coins and a long idle do not pay
    coin(1, 0, "R1 first small");
    coin(1, 0, "R1 second small");
    for (int i = 0; i < 10; i++) drive(0, 0, "R4 idle at 10");
    coin(1, 0, "R3 R5 third small pays");

    // R5: mixed orders
    coin(1, 0, "R5 small then");
    coin(0, 1, "R5 large pays");
    coin(0, 1, "R5 large then");
    coin(1, 0, "R5 small pays");

    // R7: two large coins leave 5 credit
    coin(0, 1, "R7 large one");
    coin(0, 1, "R7 large two pays");
    coin(0, 1, "R7 carried credit pays");

    // R2: held sense line counts once
    for (int i = 0; i < 6; i++) drive(1, 0, "R2 held high");
    drive(0, 0, "R2 release line");
    coin(1, 0, "R2 second small");
    coin(1, 0, "R2 third small pays");

    // R8: collision counts only the large coin
    coin(1, 1, "R8 both at once");
    coin(1, 0, "R8 small pays");

    // R9: coin during paid-15 is discarded
    coin(1, 0, "R9 setup a");
    coin(1, 0, "R9 setup b");
    drive(1, 0, "R9 paying small");
    drive(0, 1, "R9 large in paid15");
    drive(0, 0, "R9 settle");
    drive(0, 0, "R9 settle");
    coin(1, 0, "R9 after paid15 a");
    coin(1, 0, "R9 after paid15 b");
    coin(1, 0, "R9 after paid15 pays");

    // R9: coin during paid-20 is discarded
    coin(1, 0, "R9 setup c");
    coin(1, 0, "R9 setup d");
    drive(0, 1, "R9 paying large");
    drive(1, 0, "R9 small in paid20");
    drive(0, 0, "R9 settle");
    drive(0, 0, "R9 settle");
    coin(1, 0, "R9 after paid20 no pay");
    coin(1, 0, "R9 after paid20 pays");
    for (int i = 0; i < 4; i++) drive(0, 0, "R6 tail idle");

    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule